// File: doc/BRIEF.md
# Six-State Self-Correcting Counter

This block is a 3-bit synchronous counter built from three JK-style state bits. The bits are named A, B and C, and A is the most significant. It does not count in plain binary. It steps through a six-code loop and never visits the codes 011 and 111 in normal operation.

The next state of each bit comes from fixed J and K equations. Those same equations also send either unused code back into the loop on the next enabled clock, so the counter needs no separate path to detect or fix an illegal state. A count-enable input freezes the state. A synchronous reset loads a reset code, which is 000 unless the parameter `RST_CODE` says otherwise. A wrap output marks the step that closes the loop.

Typical uses are a divide-by-six timing chain or a phase sequencer. In these uses the outputs are decoded directly, and a state upset must die out by itself.

Top module: `sixcyc_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes `RST_CODE` (default 000) whatever `en` is.
- R2: With `rst` low and `en` high at each edge, `state` follows 000, 001, 010, 100, 101, 110 and then back to 000, one step per edge. The state is read as {A,B,C} = `state[2:0]`.
- R3: With `rst` low and `en` low at an edge, `state` keeps its value. This applies to every code, including 011 and 111.
- R4: Each bit obeys the JK rule on an enabled edge: J=K=0 holds, J=1 K=0 sets, J=0 K=1 clears, J=K=1 toggles. The controls are J=K=B for A; J=C, K=1 for B; and J=NOT B, K=1 for C.
- R5: `wrap` is combinational and is high exactly when `state` is 110 and `en` is high. `rst` does not affect it.
- R6: From 011, one edge with `en` high and `rst` low gives 100.
- R7: From 111, one edge with `en` high and `rst` low gives 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to `RST_CODE`, active high |
| en | input | 1 | Count enable, active high |
| state | output | 3 | Current code {A,B,C} |
| wrap | output | 1 | High when the state is 110 and `en` is high |

## Verification
The main loop is driven with a long run of enabled edges, with enable dropped at several points along it, and with a reset applied in the middle of the loop and on 110 itself. The long enabled run shows the order of the six codes. The pauses show that a frozen step does not advance. The reset on 110 shows that `wrap` follows `en` and the state, not the reset.

Two further instances reset into 011 and 111. On these, the bench checks the one-step recovery from each code. It also checks that a disabled edge leaves an illegal code in place, which shows that the recovery comes only from the JK equations.

// File: rtl/sixcyc_pkg.sv
package sixcyc_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_A   = 2;
  localparam int BIT_B   = 1;
  localparam int BIT_C   = 0;
  localparam logic [STATE_W-1:0] WRAP_CODE = 3'b110;

  typedef struct packed {
    logic j;
    logic k;
  } jk_t;

  // JK update rule for one bit.
  function automatic logic jk_next(input logic q, input jk_t c);
    case ({c.j, c.k})
      2'b00:   return q;
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      default: return ~q;
    endcase
  endfunction

  function automatic logic at_wrap(input logic [STATE_W-1:0] s);
    return s == WRAP_CODE;
  endfunction
endpackage

// File: rtl/sixcyc_jk_eqns.sv
module sixcyc_jk_eqns
  import sixcyc_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  output jk_t  [STATE_W-1:0] ctl
);
  always_comb begin
    ctl[BIT_A].j = cur[BIT_B];
    ctl[BIT_A].k = cur[BIT_B];
    ctl[BIT_B].j = cur[BIT_C];
    ctl[BIT_B].k = 1'b1;
    ctl[BIT_C].j = ~cur[BIT_B];
    ctl[BIT_C].k = 1'b1;
  end
endmodule

// File: rtl/sixcyc_jk_bit.sv
module sixcyc_jk_bit
  import sixcyc_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  jk_t  ctl,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= jk_next(q, ctl);
  end
endmodule

// File: rtl/sixcyc_wrap_det.sv
module sixcyc_wrap_det
  import sixcyc_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               en,
  output logic               wrap
);
  assign wrap = en & at_wrap(cur);
endmodule

// File: rtl/sixcyc_counter.sv
module sixcyc_counter
  import sixcyc_pkg::*;
#(
  parameter logic [2:0] RST_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] state,
  output logic       wrap
);
  jk_t [STATE_W-1:0] jk_ctl;
  logic [STATE_W-1:0] q_bits;

  sixcyc_jk_eqns u_eqns (.cur(q_bits), .ctl(jk_ctl));

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    sixcyc_jk_bit #(.RST_VAL(RST_CODE[i])) u_bit (
      .clk(clk), .rst(rst), .en(en), .ctl(jk_ctl[i]), .q(q_bits[i])
    );
  end

  sixcyc_wrap_det u_wrap (.cur(q_bits), .en(en), .wrap(wrap));

  assign state = q_bits;
endmodule

// File: rtl/sixcyc_counter_chk.sv
module sixcyc_counter_chk #(
  parameter logic [2:0] RST_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] state,
  input logic       wrap,
  input logic       ja,
  input logic       ka
);
  p_rst_r1: assert property (@(posedge clk) rst |=> state == RST_CODE);
  p_step_010_r2: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b010) |=> state == 3'b100);
  p_step_110_r2: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b110) |=> state == 3'b000);
  p_legal_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> !(state[1] && state[0]));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));
  p_toggle_a_r4: assert property (@(posedge clk) disable iff (rst)
    (en && ja && ka) |=> state[2] != $past(state[2]));
  p_wrap_r5: assert property (@(posedge clk)
    wrap |-> (en && state == 3'b110));
  p_fix011_r6: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b011) |=> state == 3'b100);
  p_fix111_r7: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b111) |=> state == 3'b000);
endmodule

bind sixcyc_counter sixcyc_counter_chk #(.RST_CODE(RST_CODE)) u_chk (
  .clk(clk), .rst(rst), .en(en), .state(state), .wrap(wrap),
  .ja(jk_ctl[2].j), .ka(jk_ctl[2].k)
);

// File: tb/sixcyc_counter_tb.sv
`timescale 1ns/1ps
module sixcyc_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] st, st3, st7;
  logic wr, wr3, wr7;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sixcyc_counter u_dut (.clk(clk), .rst(rst), .en(en), .state(st), .wrap(wr));
  sixcyc_counter #(.RST_CODE(3'b011)) u_dut_u3 (.clk(clk), .rst(rst), .en(en), .state(st3), .wrap(wr3));
  sixcyc_counter #(.RST_CODE(3'b111)) u_dut_u7 (.clk(clk), .rst(rst), .en(en), .state(st7), .wrap(wr7));

  // Each entry: {rst, en, expected wrap before the edge, expected state after it}.
  localparam int NV = 19;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,3'b001}, {1'b0,1'b1,1'b0,3'b010}, {1'b0,1'b0,1'b0,3'b010},
    {1'b0,1'b1,1'b0,3'b100}, {1'b0,1'b1,1'b0,3'b101}, {1'b0,1'b0,1'b0,3'b101},
    {1'b0,1'b1,1'b0,3'b110}, {1'b0,1'b0,1'b0,3'b110}, {1'b0,1'b1,1'b1,3'b000},
    {1'b0,1'b1,1'b0,3'b001}, {1'b0,1'b1,1'b0,3'b010}, {1'b1,1'b1,1'b0,3'b000},
    {1'b0,1'b1,1'b0,3'b001}, {1'b0,1'b1,1'b0,3'b010}, {1'b0,1'b1,1'b0,3'b100},
    {1'b0,1'b1,1'b0,3'b101}, {1'b0,1'b1,1'b0,3'b110}, {1'b1,1'b1,1'b1,3'b000},
    {1'b0,1'b1,1'b0,3'b001}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e);
    rst = r;
    en  = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0);
    chk("R1 reset state", st, 3'b000);
    chk("R1 reset code 011", st3, 3'b011);
    chk("R1 reset code 111", st7, 3'b111);
    chk("R5 wrap low in reset", wr, 0);

    // Table walk over the main loop (R2, R3, R4, R5, R1 mid-loop).
    for (int i = 0; i < NV; i++) begin
      rst = VEC[i][5];
      en  = VEC[i][4];
      #1;
      chk($sformatf("R5 wrap vec %0d", i), wr, VEC[i][3]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R1 state vec %0d", i), st, VEC[i][2:0]);
    end

    // Unused codes: bring the side instances back to their reset codes.
    step(1'b1, 1'b1);
    chk("R1 reset with en high 011", st3, 3'b011);
    chk("R1 reset with en high 111", st7, 3'b111);
    step(1'b0, 1'b0);
    chk("R3 hold 011", st3, 3'b011);
    chk("R3 hold 111", st7, 3'b111);
    en = 1'b1;
    #1;
    chk("R5 no wrap on 111", wr7, 0);
    chk("R5 no wrap on 011", wr3, 0);
    step(1'b0, 1'b1);
    chk("R6 R4 011 to 100", st3, 3'b100);
    chk("R7 R4 111 to 000", st7, 3'b000);
    step(1'b0, 1'b1);
    chk("R2 after 011 recovery", st3, 3'b101);
    chk("R2 after 111 recovery", st7, 3'b001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule